// File: doc/BRIEF.md
# Eight-Bit Accumulator ALU with Status Update

This block is the arithmetic and logic stage of a small accumulator-style 8-bit processor. It is purely combinational. An upstream decoder places the accumulator, both index registers, the fetched operand and the current status byte on its inputs, and selects one of sixteen operations. In the same cycle the block returns an 8-bit result, a code that names where the result belongs, and the new status byte. Register storage, instruction decode and memory access stay outside.

Arithmetic is binary only. The decimal flag is carried through but has no effect. Carry follows the "carry means no borrow" convention on subtraction and comparison. The block also covers the bit-test operation, which copies operand bits into the sign and overflow flags, and a combined operation that subtracts the operand from the AND of the accumulator and the X index and returns the result to X.

Top module: `alu8_core`

## Requirements
- R1: Add (op 0) produces A + operand + C modulo 256 with destination A. C becomes bit 8 of the 9-bit sum.
- R2: On add, V is set exactly when A and the operand share a sign bit and the sum's bit 7 differs from A's bit 7.
- R3: Subtract (op 1) produces A - operand - (1 - C) modulo 256 with destination A. C is set when no borrow occurs. V is set when A and the operand differ in sign and the result's sign differs from A.
- R4: The compares, op 2 against A, op 3 against X and op 4 against Y, output the difference (register - operand) modulo 256 with destination none. N, Z and C are set as in a borrow-free subtract, and V is unchanged.
- R5: Op 15 outputs ((A AND X) - operand) modulo 256 with destination X and sets N, Z and C as a compare does. V is unchanged.
- R6: AND (op 5), OR (op 6) and XOR (op 7) combine A with the operand, write A, and update only N and Z.
- R7: Bit test (op 8) outputs A AND operand with destination none. Z is set when that value is zero, N takes operand bit 7 and V takes operand bit 6.
- R8: Increment (op 9) and decrement (op 10) act on the operand modulo 256, write back to the operand location, and update only N and Z.
- R9: Shift left (op 11) moves operand bit 7 into C and fills bit 0 with zero. Shift right (op 12) moves bit 0 into C, fills bit 7 with zero, and always leaves N clear. Both have destination operand.
- R10: Rotate left (op 13) and rotate right (op 14) fill the vacated bit with the incoming C and move the expelled bit into C. Both have destination operand.
- R11: For every operation that updates them, Z is set only for a zero result and N equals result bit 7. The exception is op 8, where N follows R7.
- R12: The status layout is C bit 0, Z bit 1, I bit 2, D bit 3, B bit 4, U bit 5, V bit 6, N bit 7. Bits 2 to 5 always pass through unchanged, as does every flag the selected operation does not update. The value of D never changes any result.
- R13: The destination code is 0 for none, 1 for A, 2 for X and 3 for the operand location.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| acc_in | input | 8 | Accumulator value |
| xr_in | input | 8 | X index value |
| yr_in | input | 8 | Y index value |
| opnd_in | input | 8 | Operand byte |
| stat_in | input | 8 | Incoming status byte |
| op_sel | input | 4 | Operation select |
| result_o | output | 8 | Computed byte |
| dest_o | output | 2 | Destination code |
| stat_o | output | 8 | Updated status byte |

## Verification
The status update and the status passthrough always act in the same evaluation. One operation rewrites some flag bits, and every other bit, including D, must leave unchanged. The bench sweeps every operand pairing for every operation while the incoming status byte varies through all its bits, so set and clear values of I, D, B, U and of the flags the operation leaves alone appear next to every flag update. Each evaluation is judged as a whole: result, destination and the full status byte are compared against an independent model.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    localparam int DW     = 8;
    localparam int OPW    = 4;
    localparam int DSTW   = 2;
    localparam int MSB    = DW - 1;

    localparam int SB_C = 0;
    localparam int SB_Z = 1;
    localparam int SB_V = 6;
    localparam int SB_N = 7;

    typedef enum logic [OPW-1:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_CPA  = 4'd2,
        OP_CPX  = 4'd3,
        OP_CPY  = 4'd4,
        OP_AND  = 4'd5,
        OP_OR   = 4'd6,
        OP_XOR  = 4'd7,
        OP_TST  = 4'd8,
        OP_INC  = 4'd9,
        OP_DEC  = 4'd10,
        OP_SHL  = 4'd11,
        OP_SHR  = 4'd12,
        OP_RTL  = 4'd13,
        OP_RTR  = 4'd14,
        OP_AXM  = 4'd15
    } alu_op_e;

    typedef enum logic [DSTW-1:0] {
        DST_NONE = 2'd0,
        DST_ACC  = 2'd1,
        DST_XR   = 2'd2,
        DST_OPND = 2'd3
    } alu_dst_e;

    // which flags an operation rewrites
    typedef struct packed {
        logic n;
        logic v;
        logic z;
        logic c;
    } flag_mask_t;

    // values proposed by a datapath unit
    typedef struct packed {
        logic [DW-1:0] res;
        logic          n;
        logic          v;
        logic          c;
    } unit_out_t;

    function automatic logic is_arith(alu_op_e op);
        return (op inside {OP_ADD, OP_SUB, OP_CPA, OP_CPX, OP_CPY, OP_AXM});
    endfunction

    function automatic flag_mask_t op_mask(alu_op_e op);
        flag_mask_t m;
        m = '0;
        unique case (op)
            OP_ADD, OP_SUB:                        m = '{n:1'b1, v:1'b1, z:1'b1, c:1'b1};
            OP_CPA, OP_CPX, OP_CPY, OP_AXM:        m = '{n:1'b1, v:1'b0, z:1'b1, c:1'b1};
            OP_AND, OP_OR, OP_XOR, OP_INC, OP_DEC: m = '{n:1'b1, v:1'b0, z:1'b1, c:1'b0};
            OP_TST:                                m = '{n:1'b1, v:1'b1, z:1'b1, c:1'b0};
            OP_SHL, OP_SHR, OP_RTL, OP_RTR:        m = '{n:1'b1, v:1'b0, z:1'b1, c:1'b1};
            default:                               m = '0;
        endcase
        return m;
    endfunction

    function automatic alu_dst_e op_dest(alu_op_e op);
        alu_dst_e d;
        unique case (op)
            OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR:  d = DST_ACC;
            OP_AXM:                                 d = DST_XR;
            OP_INC, OP_DEC, OP_SHL, OP_SHR,
            OP_RTL, OP_RTR:                         d = DST_OPND;
            default:                                d = DST_NONE;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/alu8_arith.sv
module alu8_arith
    import alu8_pkg::*;
(
    input  alu_op_e       op,
    input  logic [DW-1:0] acc,
    input  logic [DW-1:0] xr,
    input  logic [DW-1:0] yr,
    input  logic [DW-1:0] opnd,
    input  logic          cin,
    output unit_out_t     uo
);
    logic [DW-1:0] lhs;
    logic [DW:0]   sum9;
    logic [DW:0]   dif9;
    logic          borrow_in;

    always_comb begin
        unique case (op)
            OP_CPX:  lhs = xr;
            OP_CPY:  lhs = yr;
            OP_AXM:  lhs = acc & xr;
            default: lhs = acc;
        endcase
    end

    // compares and the combined op subtract with no incoming borrow
    assign borrow_in = (op == OP_SUB) ? ~cin : 1'b0;
    assign sum9 = {1'b0, acc} + {1'b0, opnd} + {{DW{1'b0}}, cin};
    assign dif9 = {1'b0, lhs} - {1'b0, opnd} - {{DW{1'b0}}, borrow_in};

    always_comb begin
        if (op == OP_ADD) begin
            uo.res = sum9[DW-1:0];
            uo.c   = sum9[DW];
            uo.v   = ~(acc[MSB] ^ opnd[MSB]) & (acc[MSB] ^ sum9[MSB]);
        end else begin
            uo.res = dif9[DW-1:0];
            uo.c   = ~dif9[DW];
            uo.v   = (acc[MSB] ^ dif9[MSB]) & (acc[MSB] ^ opnd[MSB]);
        end
        uo.n = uo.res[MSB];
    end

endmodule

// File: rtl/alu8_bitwise.sv
module alu8_bitwise
    import alu8_pkg::*;
(
    input  alu_op_e       op,
    input  logic [DW-1:0] acc,
    input  logic [DW-1:0] opnd,
    input  logic          cin,
    output unit_out_t     uo
);
    always_comb begin
        uo.res = '0;
        uo.c   = cin;
        uo.v   = 1'b0;
        unique case (op)
            OP_AND: uo.res = acc & opnd;
            OP_OR:  uo.res = acc | opnd;
            OP_XOR: uo.res = acc ^ opnd;
            OP_TST: begin
                uo.res = acc & opnd;
                uo.v   = opnd[MSB-1];
            end
            OP_INC: uo.res = opnd + 1'b1;
            OP_DEC: uo.res = opnd - 1'b1;
            OP_SHL: begin
                uo.res = {opnd[MSB-1:0], 1'b0};
                uo.c   = opnd[MSB];
            end
            OP_SHR: begin
                uo.res = {1'b0, opnd[MSB:1]};
                uo.c   = opnd[0];
            end
            OP_RTL: begin
                uo.res = {opnd[MSB-1:0], cin};
                uo.c   = opnd[MSB];
            end
            OP_RTR: begin
                uo.res = {cin, opnd[MSB:1]};
                uo.c   = opnd[0];
            end
            default: uo.res = '0;
        endcase
        // bit test takes its sign flag from the operand, not the result
        uo.n = (op == OP_TST) ? opnd[MSB] : uo.res[MSB];
    end

endmodule

// File: rtl/alu8_flagunit.sv
module alu8_flagunit
    import alu8_pkg::*;
(
    input  logic [DW-1:0] stat_prev,
    input  flag_mask_t    mask,
    input  unit_out_t     uo,
    output logic [DW-1:0] stat_next
);
    always_comb begin
        stat_next = stat_prev;
        if (mask.c) stat_next[SB_C] = uo.c;
        if (mask.z) stat_next[SB_Z] = (uo.res == '0);
        if (mask.v) stat_next[SB_V] = uo.v;
        if (mask.n) stat_next[SB_N] = uo.n;
    end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
(
    input  logic [7:0] acc_in,
    input  logic [7:0] xr_in,
    input  logic [7:0] yr_in,
    input  logic [7:0] opnd_in,
    input  logic [7:0] stat_in,
    input  logic [3:0] op_sel,
    output logic [7:0] result_o,
    output logic [1:0] dest_o,
    output logic [7:0] stat_o
);
    alu_op_e    op;
    unit_out_t  arith_uo;
    unit_out_t  logic_uo;
    unit_out_t  sel_uo;
    flag_mask_t mask;

    assign op   = alu_op_e'(op_sel);
    assign mask = op_mask(op);

    alu8_arith u_arith (
        .op   (op),
        .acc  (acc_in),
        .xr   (xr_in),
        .yr   (yr_in),
        .opnd (opnd_in),
        .cin  (stat_in[SB_C]),
        .uo   (arith_uo)
    );

    alu8_bitwise u_bitwise (
        .op   (op),
        .acc  (acc_in),
        .opnd (opnd_in),
        .cin  (stat_in[SB_C]),
        .uo   (logic_uo)
    );

    assign sel_uo = is_arith(op) ? arith_uo : logic_uo;

    alu8_flagunit u_flags (
        .stat_prev (stat_in),
        .mask      (mask),
        .uo        (sel_uo),
        .stat_next (stat_o)
    );

    assign result_o = sel_uo.res;
    assign dest_o   = op_dest(op);

    // Guards relating the port-level outputs to the inputs
    always_comb begin
        // R12: control bits I, D, B, U are never rewritten
        a_r12_ctrl_passthru: assert (stat_o[5:2] == stat_in[5:2])
            else $error("control bits changed");
        // R11: zero flag agrees with the result byte when updated
        if (op != OP_TST && mask.z)
            a_r11_zero_match: assert (stat_o[SB_Z] == (result_o == 8'h00))
                else $error("Z does not match result");
        // R9: logical right shift never leaves N set
        if (op == OP_SHR)
            a_r9_shr_clears_n: assert (!stat_o[SB_N] && !result_o[7])
                else $error("right shift left N set");
        // R4: compares leave V alone and target nothing
        if (op inside {OP_CPA, OP_CPX, OP_CPY})
            a_r4_cmp_keeps_v: assert (stat_o[SB_V] == stat_in[SB_V] && dest_o == 2'd0)
                else $error("compare touched V or destination");
        // R7: bit test copies operand bits 7 and 6
        if (op == OP_TST)
            a_r7_bit_copy: assert (stat_o[SB_N] == opnd_in[7] && stat_o[SB_V] == opnd_in[6])
                else $error("bit test flag copy wrong");
    end

endmodule

// File: tb/sim_alu8_core.sv
`timescale 1ns/100ps
module sim_alu8_core;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] acc_in, xr_in, yr_in, opnd_in, stat_in;
    logic [3:0] op_sel;
    logic [7:0] result_o;
    logic [1:0] dest_o;
    logic [7:0] stat_o;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  finished = 1'b0;

    always #10 clk = ~clk;

    alu8_core u0 (
        .acc_in   (acc_in),
        .xr_in    (xr_in),
        .yr_in    (yr_in),
        .opnd_in  (opnd_in),
        .stat_in  (stat_in),
        .op_sel   (op_sel),
        .result_o (result_o),
        .dest_o   (dest_o),
        .stat_o   (stat_o)
    );

    // Independent integer model of the requirements
    function automatic void ref_model(input int op, input int a, input int x, input int y,
                                      input int m, input logic [7:0] p,
                                      output logic [7:0] r, output logic [1:0] d,
                                      output logic [7:0] s);
        int t;
        int cy;
        logic zn;
        cy = p[0] ? 1 : 0;
        s  = p;
        zn = 1'b1;
        t  = 0;
        case (op)
            0: begin t = a + m + cy; s[0] = (t > 255); d = 2'd1;
                     s[6] = ((a >= 128) == (m >= 128)) && (((t % 256) >= 128) != (a >= 128)); end
            1: begin t = a - m - (1 - cy); s[0] = (t >= 0); d = 2'd1;
                     s[6] = ((a >= 128) != (m >= 128)) && ((((t + 512) % 256) >= 128) != (a >= 128)); end
            2: begin t = a - m; s[0] = (t >= 0); d = 2'd0; end
            3: begin t = x - m; s[0] = (t >= 0); d = 2'd0; end
            4: begin t = y - m; s[0] = (t >= 0); d = 2'd0; end
            5: begin t = a & m; d = 2'd1; end
            6: begin t = a | m; d = 2'd1; end
            7: begin t = a ^ m; d = 2'd1; end
            8: begin t = a & m; d = 2'd0; zn = 1'b0;
                     s[1] = (t == 0); s[7] = (m >= 128); s[6] = ((m / 64) % 2 == 1); end
            9: begin t = m + 1; d = 2'd3; end
            10: begin t = m - 1; d = 2'd3; end
            11: begin t = m * 2; s[0] = (m >= 128); d = 2'd3; end
            12: begin t = m / 2; s[0] = (m % 2 == 1); d = 2'd3; end
            13: begin t = m * 2 + cy; s[0] = (m >= 128); d = 2'd3; end
            14: begin t = m / 2 + 128 * cy; s[0] = (m % 2 == 1); d = 2'd3; end
            default: begin t = (a & x) - m; s[0] = (t >= 0); d = 2'd2; end
        endcase
        r = 8'((t + 512) % 256);
        if (zn) begin
            s[1] = (r == 8'h00);
            s[7] = r[7];
        end
    endfunction

    task automatic apply_check(input int op, input int a, input int x, input int y,
                               input int m, input logic [7:0] p, input string tag);
        logic [7:0] er;
        logic [1:0] ed;
        logic [7:0] es;
        op_sel  = 4'(op);
        acc_in  = 8'(a);
        xr_in   = 8'(x);
        yr_in   = 8'(y);
        opnd_in = 8'(m);
        stat_in = p;
        #0.5;
        ref_model(op, a, x, y, m, p, er, ed, es);
        n_checks++;
        if (result_o !== er || dest_o !== ed || stat_o !== es) begin
            n_errors++;
            $display("FAIL %s op=%0d a=%h x=%h y=%h m=%h p=%h: got r=%h d=%0d s=%h expected r=%h d=%0d s=%h",
                     tag, op, a, x, y, m, p, result_o, dest_o, stat_o, er, ed, es);
        end
        #0.5;
    endtask

    // full operand sweep for one operation, with a status byte that cycles every bit
    task automatic sweep_op(input int op, input string tag);
        for (int i = 0; i < 256; i++) begin
            for (int j = 0; j < 256; j++) begin
                apply_check(op, i, (i * 37 + j) % 256, (j * 11 + i) % 256, j,
                            8'((i * 7 + j * 3) % 256), tag);
            end
        end
    endtask

    // R12: all-zero inputs give a zero sum with Z set, nothing else
    task automatic t_idle_state();
        apply_check(0, 0, 0, 0, 0, 8'h00, "R12 idle inputs");
    endtask

    task automatic t_add();
        apply_check(0, 8'h7F, 0, 0, 8'h01, 8'h00, "R2 signed overflow");
        apply_check(0, 8'hFF, 0, 0, 8'h00, 8'h01, "R1 carry wrap to zero");
        apply_check(0, 8'h10, 0, 0, 8'h20, 8'h08, "R12 decimal flag ignored on add");
        sweep_op(0, "R1 R2 add");
    endtask

    task automatic t_sub();
        apply_check(1, 8'h80, 0, 0, 8'h01, 8'h01, "R3 signed overflow");
        apply_check(1, 8'h00, 0, 0, 8'h00, 8'h00, "R3 borrow in");
        apply_check(1, 8'h15, 0, 0, 8'h06, 8'h09, "R12 decimal flag ignored on sub");
        sweep_op(1, "R3 sub");
    endtask

    task automatic t_compare();
        apply_check(2, 8'h40, 0, 0, 8'h40, 8'h40, "R4 equal keeps V");
        sweep_op(2, "R4 cmp A");
        sweep_op(3, "R4 cmp X");
        sweep_op(4, "R4 cmp Y");
    endtask

    task automatic t_combined();
        apply_check(15, 8'hF0, 8'h3C, 0, 8'h30, 8'h00, "R5 zero difference");
        sweep_op(15, "R5 and-sub to X");
    endtask

    task automatic t_logic();
        sweep_op(5, "R6 and");
        sweep_op(6, "R6 or");
        sweep_op(7, "R6 xor");
    endtask

    task automatic t_bit();
        apply_check(8, 8'h00, 0, 0, 8'hC0, 8'h00, "R7 zero with copies");
        sweep_op(8, "R7 bit test");
    endtask

    task automatic t_incdec();
        apply_check(9, 0, 0, 0, 8'hFF, 8'h00, "R8 inc wraps");
        apply_check(10, 0, 0, 0, 8'h00, 8'h00, "R8 dec wraps");
        sweep_op(9, "R8 inc");
        sweep_op(10, "R8 dec");
    endtask

    task automatic t_shift();
        apply_check(12, 0, 0, 0, 8'h01, 8'h80, "R9 shr clears N");
        sweep_op(11, "R9 shl");
        sweep_op(12, "R9 shr");
    endtask

    task automatic t_rotate();
        apply_check(13, 0, 0, 0, 8'h80, 8'h00, "R10 rol to zero");
        apply_check(14, 0, 0, 0, 8'h00, 8'h01, "R10 ror carry in");
        sweep_op(13, "R10 rol");
        sweep_op(14, "R10 ror");
    endtask

    // R11 and R13 are judged on every evaluation above via the full model

    initial begin
        #(20 * 190000);
        if (!finished) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        op_sel = '0; acc_in = '0; xr_in = '0; yr_in = '0; opnd_in = '0; stat_in = '0;
        repeat (2) @(posedge clk);
        rst = 1'b0;
        #3.2;
        t_idle_state();
        t_add();
        t_sub();
        t_compare();
        t_combined();
        t_logic();
        t_bit();
        t_incdec();
        t_shift();
        t_rotate();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule